// File: doc/BRIEF.md
# Serial Bus Node Control and Status Register

This block holds the eight-bit control and status register of one node on a shared, multi-master serial bus, together with the node's interrupt logic. A processor reaches it through a simple register port: a combinational read of the whole register at one decoded address, and a single-cycle write that updates the control bits and can clear the interrupt flag by writing a one to it.

The bus engine around it reports protocol events as single-cycle pulses: the start of any message on the bus, the start of a message this node sends, the acknowledge sample taken at timing state 36 together with the data line level, a match of the incoming 3-bit bus address field against this node's address, and the processor's read of the last byte of a received message. From these the block keeps the not-acknowledged, read-pending, deaf and write-pending status bits. Software owns the master, previous-master and serial-clock-enable bits. The clock-enable and master bits, and the deaf condition, leave the block as enable outputs. A level interrupt request is raised whenever the bus-control enable input is high and a source bit is set.

A two-stage synchronizer sits on the asynchronous active-low reset, so internal state leaves reset on the second clock edge after the reset input goes high.

Top module: `sbus_csr`

## Requirements
- R1: While reset is asserted, and until the second clock edge after its release, every register bit reads 0 and `irq_o`, `sclk_en_o`, `master_o` and `deaf_o` are 0.
- R2: With `addr_i` equal to the register address (default 0x19), `rdata_o` returns the register as {bit7 interrupt flag, bit6 serial clock enable, bit5 deaf, bit4 read pending, bit3 not acknowledged, bit2 previous master, bit1 master, bit0 write pending} in the same cycle. At any other address it returns 0.
- R3: A write (`wr_en_i` high at the register address) loads `wdata_i` bits 6, 2 and 1 into the clock-enable, previous-master and master bits at the next edge. A write to any other address changes nothing.
- R4: Writes never change bits 5, 4, 3 and 0. Writing ones there has no effect.
- R5: An `ack_sample_i` pulse with `sda_i` high sets not-acknowledged. With `sda_i` low it does not. A `tx_start_i` pulse clears it. When a set and a clear occur in the same cycle, the set wins.
- R6: An `addr_match_i` pulse sets read-pending and a `last_read_i` pulse clears it. When both occur in the same cycle, the set wins.
- R7: A `msg_start_i` pulse while read-pending is set sets deaf. A `msg_start_i` pulse while read-pending is clear clears deaf. `deaf_o` follows the deaf bit.
- R8: `irq_o` equals `bus_en_i` AND (master OR not-acknowledged OR read-pending). It follows `bus_en_i` in the same cycle.
- R9: The interrupt flag is set at the edge that ends any cycle in which `irq_o` is high. Writing 1 to bit 7 clears it unless `irq_o` is high in that cycle. Writing 0 to bit 7 leaves it unchanged.
- R10: `sclk_en_o` follows the clock-enable bit and `master_o` follows the master bit.
- R11: Bit 0 (write pending) holds the value of `tx_pend_i` from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W (8) | Processor register address |
| wr_en_i | input | 1 | Processor write strobe |
| wdata_i | input | 8 | Processor write data |
| rdata_o | output | 8 | Register read data, 0 when not addressed |
| bus_en_i | input | 1 | Bus-control interrupt enable |
| msg_start_i | input | 1 | Pulse: any message begins on the bus |
| tx_start_i | input | 1 | Pulse: this node begins sending a message |
| ack_sample_i | input | 1 | Pulse: acknowledge sampling point (timing state 36) |
| sda_i | input | 1 | Serial data level at the acknowledge sample |
| addr_match_i | input | 1 | Pulse: incoming address field matches this node |
| last_read_i | input | 1 | Pulse: processor read the last message byte |
| tx_pend_i | input | 1 | Transmit-pending level from the bus engine |
| irq_o | output | 1 | Level interrupt request |
| sclk_en_o | output | 1 | Serial clock generator enable |
| master_o | output | 1 | Node is bus master |
| deaf_o | output | 1 | Node cannot receive the current message |

## Verification
Read data and the interrupt request are combinational, so they are due in the cycle the address or enable changes. Every register bit is due one edge after its event or write, and the interrupt flag one edge after `irq_o` rises, which is two edges after the source event. The bench drives inputs just after the falling edge, lets one rising edge pass, and compares all outputs against its model one nanosecond after the next falling edge. Same-cycle comparisons are made a fraction of a nanosecond after the inputs change, well before the next rising edge.

// File: rtl/sbus_csr_pkg.sv
package sbus_csr_pkg;

  localparam int CSR_W = 8;

  localparam int BIT_FLAG   = 7;
  localparam int BIT_SCLK   = 6;
  localparam int BIT_DEAF   = 5;
  localparam int BIT_RDPEND = 4;
  localparam int BIT_NACK   = 3;
  localparam int BIT_PREV   = 2;
  localparam int BIT_MASTER = 1;
  localparam int BIT_WPEND  = 0;

  typedef struct packed {
    logic sclk_en;
    logic prev_master;
    logic master;
  } ctrl_t;

  typedef struct packed {
    logic deaf;
    logic rdpend;
    logic nack;
    logic wpend;
  } stat_t;

endpackage

// File: rtl/sbus_csr_ctrl.sv
module sbus_csr_ctrl
  import sbus_csr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_hit_i,
  input  ctrl_t wr_val_i,
  output ctrl_t ctrl_o
);

  ctrl_t ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_hit_i) ctrl_d = wr_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;

  a_r3_write_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit_i |=> ctrl_q == $past(wr_val_i));

  a_r3_no_write_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hit_i |=> $stable(ctrl_q));

endmodule

// File: rtl/sbus_csr_stat.sv
module sbus_csr_stat
  import sbus_csr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  msg_start_i,
  input  logic  tx_start_i,
  input  logic  ack_sample_i,
  input  logic  sda_i,
  input  logic  addr_match_i,
  input  logic  last_read_i,
  input  logic  tx_pend_i,
  output stat_t stat_o
);

  stat_t stat_q, stat_d;
  logic  nack_set;

  assign nack_set = ack_sample_i & sda_i;

  always_comb begin
    stat_d       = stat_q;
    stat_d.wpend = tx_pend_i;
    // set takes priority over clear
    if (nack_set)        stat_d.nack = 1'b1;
    else if (tx_start_i) stat_d.nack = 1'b0;
    if (addr_match_i)     stat_d.rdpend = 1'b1;
    else if (last_read_i) stat_d.rdpend = 1'b0;
    // deaf decided from read-pending as it stood when the message began
    if (msg_start_i) stat_d.deaf = stat_q.rdpend;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;
  end

  assign stat_o = stat_q;

  a_r5_nack_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_sample_i && sda_i) |=> stat_q.nack);

  a_r5_nack_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_start_i && !(ack_sample_i && sda_i)) |=> !stat_q.nack);

  a_r6_rdpend_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_match_i |=> stat_q.rdpend);

  a_r6_rdpend_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_read_i && !addr_match_i) |=> !stat_q.rdpend);

  a_r7_deaf_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_start_i && stat_q.rdpend) |=> stat_q.deaf);

  a_r7_deaf_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_start_i && !stat_q.rdpend) |=> !stat_q.deaf);

  a_r11_wpend_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> stat_q.wpend == $past(tx_pend_i));

endmodule

// File: rtl/sbus_csr_irq.sv
module sbus_csr_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_en_i,
  input  logic src_master_i,
  input  logic src_nack_i,
  input  logic src_rdpend_i,
  input  logic clr_req_i,
  output logic irq_o,
  output logic flag_o
);

  logic flag_q, flag_d;
  logic any_src;

  assign any_src = src_master_i | src_nack_i | src_rdpend_i;
  assign irq_o   = bus_en_i & any_src;

  always_comb begin
    flag_d = flag_q;
    if (irq_o)          flag_d = 1'b1;
    else if (clr_req_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  a_r9_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> flag_q);

  a_r9_flag_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_req_i) |=> flag_q);

  a_r9_flag_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_req_i && !irq_o) |=> !flag_q);

  a_r8_irq_needs_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (bus_en_i && $countones({src_master_i, src_nack_i, src_rdpend_i}) != 0));

endmodule

// File: rtl/sbus_csr.sv
module sbus_csr
  import sbus_csr_pkg::*;
#(
  parameter int              ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR  = 8'h19,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [CSR_W-1:0]  wdata_i,
  output logic [CSR_W-1:0]  rdata_o,
  input  logic              bus_en_i,
  input  logic              msg_start_i,
  input  logic              tx_start_i,
  input  logic              ack_sample_i,
  input  logic              sda_i,
  input  logic              addr_match_i,
  input  logic              last_read_i,
  input  logic              tx_pend_i,
  output logic              irq_o,
  output logic              sclk_en_o,
  output logic              master_o,
  output logic              deaf_o
);

  localparam int SYNC_N = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  // reset: asserted asynchronously, released through a synchronizer
  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end

  assign rst_n = rst_sync_q[SYNC_N-1];

  logic  sel, wr_hit;
  ctrl_t wr_val, ctrl;
  stat_t stat;
  logic  flag;

  assign sel    = (addr_i == REG_ADDR);
  assign wr_hit = wr_en_i & sel;

  assign wr_val.sclk_en     = wdata_i[BIT_SCLK];
  assign wr_val.prev_master = wdata_i[BIT_PREV];
  assign wr_val.master      = wdata_i[BIT_MASTER];

  sbus_csr_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .wr_hit_i (wr_hit),
    .wr_val_i (wr_val),
    .ctrl_o   (ctrl)
  );

  sbus_csr_stat u_stat (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .msg_start_i  (msg_start_i),
    .tx_start_i   (tx_start_i),
    .ack_sample_i (ack_sample_i),
    .sda_i        (sda_i),
    .addr_match_i (addr_match_i),
    .last_read_i  (last_read_i),
    .tx_pend_i    (tx_pend_i),
    .stat_o       (stat)
  );

  sbus_csr_irq u_irq (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .bus_en_i     (bus_en_i),
    .src_master_i (ctrl.master),
    .src_nack_i   (stat.nack),
    .src_rdpend_i (stat.rdpend),
    .clr_req_i    (wr_hit & wdata_i[BIT_FLAG]),
    .irq_o        (irq_o),
    .flag_o       (flag)
  );

  logic [CSR_W-1:0] csr_word;

  always_comb begin
    csr_word             = '0;
    csr_word[BIT_FLAG]   = flag;
    csr_word[BIT_SCLK]   = ctrl.sclk_en;
    csr_word[BIT_DEAF]   = stat.deaf;
    csr_word[BIT_RDPEND] = stat.rdpend;
    csr_word[BIT_NACK]   = stat.nack;
    csr_word[BIT_PREV]   = ctrl.prev_master;
    csr_word[BIT_MASTER] = ctrl.master;
    csr_word[BIT_WPEND]  = stat.wpend;
  end

  assign rdata_o   = sel ? csr_word : '0;
  assign sclk_en_o = ctrl.sclk_en;
  assign master_o  = ctrl.master;
  assign deaf_o    = stat.deaf;

  a_r1_quiet_in_reset: assert property (@(posedge clk_i)
    !rst_n |-> (!irq_o && !sclk_en_o && !master_o && !deaf_o));

  a_r4_status_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_hit && (|{wdata_i[BIT_DEAF], wdata_i[BIT_RDPEND], wdata_i[BIT_NACK], wdata_i[BIT_WPEND]})
     && !msg_start_i && !tx_start_i && !ack_sample_i && !addr_match_i && !last_read_i)
    |=> $stable({stat.deaf, stat.rdpend, stat.nack}));

  a_r2_unselected_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_n)
    !sel |-> rdata_o == '0);

endmodule

// File: tb/sim_sbus_csr.sv
`timescale 1ns/100ps
module sim_sbus_csr;

  localparam real HALF = 2.5;
  localparam logic [7:0] RA = 8'h19;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [7:0] addr_i;
  logic       wr_en_i;
  logic [7:0] wdata_i;
  logic [7:0] rdata_o;
  logic       bus_en_i, msg_start_i, tx_start_i, ack_sample_i, sda_i;
  logic       addr_match_i, last_read_i, tx_pend_i;
  logic       irq_o, sclk_en_o, master_o, deaf_o;

  always #(HALF) clk_i = ~clk_i;

  sbus_csr u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .bus_en_i(bus_en_i),
    .msg_start_i(msg_start_i), .tx_start_i(tx_start_i),
    .ack_sample_i(ack_sample_i), .sda_i(sda_i), .addr_match_i(addr_match_i),
    .last_read_i(last_read_i), .tx_pend_i(tx_pend_i), .irq_o(irq_o),
    .sclk_en_o(sclk_en_o), .master_o(master_o), .deaf_o(deaf_o)
  );

  int errors = 0;
  int checks = 0;

  // behavioural reference model
  bit m_flag, m_sclk, m_deaf, m_rdp, m_nack, m_prev, m_mst, m_wpd;
  int rel_edges;

  function automatic bit [7:0] m_word();
    return {m_flag, m_sclk, m_deaf, m_rdp, m_nack, m_prev, m_mst, m_wpd};
  endfunction

  function automatic bit m_irq();
    return bus_en_i && (m_mst || m_nack || m_rdp);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rel_edges = 0;
      {m_flag, m_sclk, m_deaf, m_rdp, m_nack, m_prev, m_mst, m_wpd} = '0;
    end else if (rel_edges < 2) begin
      rel_edges++;
    end else begin
      bit req, hit, old_rdp;
      req = m_irq();
      hit = wr_en_i && (addr_i == RA);
      old_rdp = m_rdp;
      if (hit) begin
        m_sclk = wdata_i[6];
        m_prev = wdata_i[2];
        m_mst  = wdata_i[1];
      end
      if (ack_sample_i && sda_i) m_nack = 1;
      else if (tx_start_i)       m_nack = 0;
      if (addr_match_i)      m_rdp = 1;
      else if (last_read_i)  m_rdp = 0;
      if (msg_start_i) m_deaf = old_rdp;
      m_wpd = tx_pend_i;
      if (req) m_flag = 1;
      else if (hit && wdata_i[7]) m_flag = 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2 rdata vs model", rdata_o, (addr_i == RA) ? m_word() : 8'h00);
    chk("R8 irq vs model", irq_o, m_irq());
    chk("R10 sclk_en vs model", sclk_en_o, m_sclk);
    chk("R10 master vs model", master_o, m_mst);
    chk("R7 deaf_o vs model", deaf_o, m_deaf);
  endtask

  task automatic idle();
    wr_en_i = 0; wdata_i = 0; msg_start_i = 0; tx_start_i = 0;
    ack_sample_i = 0; sda_i = 0; addr_match_i = 0; last_read_i = 0;
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
    #1;
    compare_all();
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr_i = a; wr_en_i = 1; wdata_i = d;
    tick();
    idle();
    addr_i = RA;
  endtask

  task automatic peek(input string tag, input logic [7:0] a, input int exp);
    addr_i = a;
    #0.5;
    chk(tag, rdata_o, exp);
    addr_i = RA;
  endtask

  initial begin
    #(200000 * 2 * HALF);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_ni = 0; addr_i = RA; bus_en_i = 1; tx_pend_i = 0;
    idle();
    repeat (3) @(negedge clk_i);
    #1;
    compare_all();
    chk("R1 irq in reset", irq_o, 0);
    chk("R1 rdata in reset", rdata_o, 8'h00);
    rst_ni = 1;
    repeat (3) tick();
    chk("R1 after release", rdata_o, 8'h00);

    // R3 R4 R10: control bits load, status bits ignore writes
    wr(RA, 8'hFF);
    peek("R3 R4 write FF", RA, 8'h46);
    chk("R10 sclk_en_o", sclk_en_o, 1);
    chk("R10 master_o", master_o, 1);
    tick();
    peek("R9 flag set after irq", RA, 8'hC6);
    wr(8'h18, 8'h00);
    peek("R3 other address ignored", RA, 8'hC6);

    // R9: clear behaviour
    wr(RA, 8'h80);
    peek("R9 clear blocked while irq", RA, 8'h80);
    tick();
    peek("R9 flag holds", RA, 8'h80);
    wr(RA, 8'h00);
    peek("R9 write zero no effect", RA, 8'h80);
    wr(RA, 8'h80);
    peek("R9 write one clears", RA, 8'h00);

    // R5: not acknowledged
    ack_sample_i = 1; sda_i = 0; tick(); idle();
    peek("R5 sda low no nack", RA, 8'h00);
    ack_sample_i = 1; sda_i = 1; tick(); idle();
    peek("R5 sda high sets nack", RA, 8'h08);
    chk("R8 irq from nack", irq_o, 1);
    tx_start_i = 1; tick(); idle();
    peek("R5 tx start clears nack", RA, 8'h80);
    wr(RA, 8'h80);
    ack_sample_i = 1; sda_i = 1; tx_start_i = 1; tick(); idle();
    peek("R5 set wins over clear", RA, 8'h08);
    tx_start_i = 1; tick(); idle();
    wr(RA, 8'h80);
    peek("R5 cleaned", RA, 8'h00);

    // R6 R7: read pending and deaf
    addr_match_i = 1; tick(); idle();
    peek("R6 match sets rdpend", RA, 8'h10);
    addr_match_i = 1; last_read_i = 1; tick(); idle();
    peek("R6 set wins over clear", RA, 8'h90);
    msg_start_i = 1; tick(); idle();
    peek("R7 deaf on unread start", RA, 8'hB0);
    chk("R7 deaf_o high", deaf_o, 1);
    last_read_i = 1; tick(); idle();
    peek("R6 last read clears", RA, 8'hA0);
    msg_start_i = 1; tick(); idle();
    peek("R7 deaf cleared", RA, 8'h80);
    chk("R7 deaf_o low", deaf_o, 0);
    wr(RA, 8'h80);

    // R8: enable gating
    bus_en_i = 0;
    addr_match_i = 1; tick(); idle();
    chk("R8 irq gated off", irq_o, 0);
    tick();
    peek("R8 no flag while gated", RA, 8'h10);
    bus_en_i = 1;
    #0.5;
    chk("R8 irq same cycle as enable", irq_o, 1);
    last_read_i = 1; tick(); idle();
    peek("R9 flag after gated irq", RA, 8'h80);
    wr(RA, 8'h80);

    // R11 and R4: write pending
    tx_pend_i = 1; tick();
    peek("R11 wpend follows", RA, 8'h01);
    wr(RA, 8'h39);
    peek("R4 status write ignored", RA, 8'h01);
    tx_pend_i = 0; tick();
    peek("R11 wpend drops", RA, 8'h00);

    // R2: address decode
    wr(RA, 8'h40);
    peek("R2 selected read", RA, 8'h40);
    peek("R2 unselected read zero", 8'h20, 8'h00);

    // random phase, compared against the model every cycle
    for (int i = 0; i < 3000; i++) begin
      addr_i       = ($urandom % 4 == 0) ? 8'(($urandom % 3) + 8'h18) : RA;
      wr_en_i      = ($urandom % 8 == 0);
      wdata_i      = 8'($urandom);
      bus_en_i     = ($urandom % 5 != 0);
      msg_start_i  = ($urandom % 6 == 0);
      tx_start_i   = ($urandom % 6 == 0);
      ack_sample_i = ($urandom % 6 == 0);
      sda_i        = 1'($urandom);
      addr_match_i = ($urandom % 6 == 0);
      last_read_i  = ($urandom % 6 == 0);
      tx_pend_i    = 1'($urandom);
      tick();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule